// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block moves single characters between a simple register bus and an external device over a parallel data bus. Two single-wire control pins carry the handshake: one input pin (strobe-in) and one output pin (strobe-out). Both are active low. Software drives every transfer directly. In receive direction, a falling strobe on the input pin latches the data lines and raises a receive event. A read of the data register then answers with an acknowledge on the output pin. In transmit direction, a write of the data register puts the character on the data lines and lowers the output strobe. An acknowledge falling on the input pin then raises a transmit event.

Two handshake shapes are offered. In interlocked mode the output pin stays low until the input pin answers. In pulsed mode the output pin drops for a programmable number of clocks. Events sit in a write-one-to-clear register. An enable mask gates them onto a single interrupt output. A handshake controller state machine sequences each transfer through these states:

- `ST_IDLE`
- `ST_RX_FULL`
- `ST_RX_ACK_HOLD`
- `ST_RX_ACK_PULSE`
- `ST_TX_STB_HOLD`
- `ST_TX_STB_PULSE`
- `ST_TX_WAIT_ACK`

The state transitions are:

- Receive path: `ST_IDLE` → `ST_RX_FULL` on a synchronized strobe fall. `ST_RX_FULL` → `ST_RX_ACK_HOLD` or `ST_RX_ACK_PULSE` on a data read. `ST_RX_ACK_HOLD` → `ST_IDLE` once the synchronized strobe is high. `ST_RX_ACK_PULSE` → `ST_IDLE` when its count expires.
- Transmit path: `ST_IDLE` → `ST_TX_STB_HOLD` or `ST_TX_STB_PULSE` on a data write. `ST_TX_STB_HOLD` → `ST_IDLE` on an acknowledge fall. `ST_TX_STB_PULSE` → `ST_TX_WAIT_ACK` when its count expires. `ST_TX_WAIT_ACK` → `ST_IDLE` on an acknowledge fall.
- Any state → `ST_IDLE` whenever the port is inactive.

The register map uses a 2-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | Configuration | Read/write |
| 1 | Data | Read returns the received character; write launches a transmit |
| 2 | Events | Write-one-to-clear |
| 3 | Interrupt mask | Read/write |

Top module: `pport_hs_ctrl`

## Requirements
- R1: After reset the output strobe is high, the data output enable is low, the interrupt is low, and the configuration, event and mask registers read zero.
- R2: The port is active only when configuration bit 3 (software control) is 1 and the mode field (bits 2:1) is 00 (interlocked) or 01 (pulsed). While the port is inactive, the output strobe stays high, data writes leave the data output unchanged, and strobe-in activity sets no event.
- R3: The data output enable equals configuration bit 0 (1 = transmit, 0 = receive).
- R4: In receive direction, a falling edge on strobe-in passes a two-flop synchronizer. On the third rising clock edge after the pin falls, the data lines are latched into the data register and event bit 0 (receive) is set.
- R5: In receive direction with a character pending, a read of address 1 lowers the output strobe from the clock edge that samples the read. In interlocked mode the strobe returns high on the third clock edge after strobe-in rises.
- R6: In pulsed mode, every output strobe is low for exactly N clocks, where N is configuration bits 15:8; a value of 0 counts as 1.
- R7: In transmit direction with the port idle, a write of address 1 updates the data output and lowers the output strobe from the clock edge that samples the write.
- R8: In interlocked transmit, the output strobe returns high and event bit 1 (transmit) is set on the third clock edge after strobe-in falls.
- R9: In pulsed transmit, after the pulse the port waits for strobe-in to fall. Event bit 1 is set on the third clock edge after that fall.
- R10: A data write in transmit direction while a transfer is in progress leaves the data output unchanged and sets event bit 2 (overrun) on the sampling edge.
- R11: Writing 1 to an event bit clears it. A new event on the same edge as the clear wins, and the bit stays set.
- R12: The interrupt output is high exactly when some event bit is set and its matching bit in the mask register (address 3) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | RW (16) | Write data |
| bus_rdata | output | RW (16) | Combinational read data for `bus_addr` |
| pd_in | input | DW (8) | Parallel data lines, input side |
| pd_out | output | DW (8) | Parallel data lines, output side |
| pd_oe | output | 1 | Output enable for the data lines |
| stb_in_n | input | 1 | Strobe or acknowledge from the device, active low |
| stb_out_n | output | 1 | Strobe or acknowledge to the device, active low |
| irq | output | 1 | Interrupt request |

## Verification
Register accesses act on the single rising edge that samples them. The data output, output strobe, overrun bit and mask-gated interrupt therefore change right after that edge. Anything caused by strobe-in passes two synchronizer flops and one edge-detect stage, so its effect lands on the third rising edge after the pin moves.

The bench drives every input on a falling edge. It samples outputs and register reads on later falling edges. Each pin-driven check first looks after the second edge, where nothing may have changed yet, and then after the third edge, where the result must be present.

Pulse widths are confirmed by sampling the output strobe after each edge from launch to release.

// File: rtl/pport_pkg.sv
package pport_pkg;

    // register addresses
    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_EVT  = 2'd2;
    localparam logic [1:0] ADDR_MASK = 2'd3;

    // configuration field positions
    localparam int CFG_DIR_BIT  = 0;
    localparam int CFG_MODE_LSB = 1;
    localparam int CFG_HOST_BIT = 3;
    localparam int CFG_PW_LSB   = 8;

    // handshake mode encodings
    localparam logic [1:0] MODE_ILOCK = 2'b00;
    localparam logic [1:0] MODE_PULSE = 2'b01;

    // event bit positions
    localparam int EV_RX  = 0;
    localparam int EV_TX  = 1;
    localparam int EV_OVR = 2;
    localparam int EV_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_FULL,
        ST_RX_ACK_HOLD,
        ST_RX_ACK_PULSE,
        ST_TX_STB_HOLD,
        ST_TX_STB_PULSE,
        ST_TX_WAIT_ACK
    } hs_state_e;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic fell
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl  = chain_q[STAGES-1];
    assign fell = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pport_evt.sv
module pport_evt #(
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] set_bits,
    input  logic          clr_we,
    input  logic [EW-1:0] clr_bits,
    input  logic [EW-1:0] mask,
    output logic [EW-1:0] ev,
    output logic          irq
);
    logic [EW-1:0] ev_d;

    always_comb begin
        ev_d = ev;
        if (clr_we) ev_d = ev_d & ~clr_bits;
        // a fresh event outranks a clear on the same edge
        ev_d = ev_d | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev <= '0;
        else        ev <= ev_d;
    end

    assign irq = |(ev & mask);
endmodule

// File: rtl/pport_hs_fsm.sv
module pport_hs_fsm
    import pport_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            tx_dir,
    input  logic            pulsed,
    input  logic [PW_W-1:0] pw_eff,
    input  logic            stb_fall,
    input  logic            stb_high,
    input  logic            data_rd,
    input  logic            data_wr,
    output logic            stb_out_n,
    output logic            rx_take,
    output logic            tx_go,
    output logic            tx_done,
    output logic            ovr_hit
);
    hs_state_e       st_q, st_d;
    logic [PW_W-1:0] cnt_q;
    logic            load_cnt;

    // next state and transition strobes
    always_comb begin
        st_d     = st_q;
        load_cnt = 1'b0;
        rx_take  = 1'b0;
        tx_go    = 1'b0;
        tx_done  = 1'b0;
        ovr_hit  = 1'b0;
        if (!active) begin
            st_d = ST_IDLE;
        end else begin
            ovr_hit = data_wr & tx_dir & (st_q != ST_IDLE);
            unique case (st_q)
                ST_IDLE: begin
                    if (tx_dir) begin
                        if (data_wr) begin
                            tx_go    = 1'b1;
                            load_cnt = 1'b1;
                            st_d     = pulsed ? ST_TX_STB_PULSE : ST_TX_STB_HOLD;
                        end
                    end else if (stb_fall) begin
                        rx_take = 1'b1;
                        st_d    = ST_RX_FULL;
                    end
                end
                ST_RX_FULL: begin
                    if (data_rd) begin
                        load_cnt = 1'b1;
                        st_d     = pulsed ? ST_RX_ACK_PULSE : ST_RX_ACK_HOLD;
                    end
                end
                ST_RX_ACK_HOLD: begin
                    if (stb_high) st_d = ST_IDLE;
                end
                ST_RX_ACK_PULSE: begin
                    if (cnt_q == '0) st_d = ST_IDLE;
                end
                ST_TX_STB_HOLD: begin
                    if (stb_fall) begin
                        tx_done = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end
                ST_TX_STB_PULSE: begin
                    if (cnt_q == '0) st_d = ST_TX_WAIT_ACK;
                end
                ST_TX_WAIT_ACK: begin
                    if (stb_fall) begin
                        tx_done = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_cnt)     cnt_q <= pw_eff - 1'b1;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // outputs from state
    always_comb begin
        stb_out_n = 1'b1;
        if (st_q inside {ST_RX_ACK_HOLD, ST_RX_ACK_PULSE,
                         ST_TX_STB_HOLD, ST_TX_STB_PULSE})
            stb_out_n = 1'b0;
    end
endmodule

// File: rtl/pport_hs_ctrl.sv
module pport_hs_ctrl
    import pport_pkg::*;
#(
    parameter int DW          = 8,
    parameter int RW          = 16,
    parameter int PW_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [RW-1:0] bus_wdata,
    output logic [RW-1:0] bus_rdata,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic          stb_in_n,
    output logic          stb_out_n,
    output logic          irq
);
    localparam logic [PW_W-1:0] PW_ONE = PW_W'(1);

    logic            cfg_dir, cfg_host;
    logic [1:0]      cfg_mode;
    logic [PW_W-1:0] cfg_pw;
    logic [EV_W-1:0] mask_q;
    logic [EV_W-1:0] ev;
    logic [DW-1:0]   rx_q, tx_q;

    logic wr_cfg, wr_data, wr_evt, wr_mask, rd_data;
    logic active, pulsed;
    logic [PW_W-1:0] pw_eff;
    logic stb_lvl, stb_fall;
    logic rx_take, tx_go, tx_done, ovr_hit;
    logic unused_wbits;

    assign wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_evt  = bus_wr && (bus_addr == ADDR_EVT);
    assign wr_mask = bus_wr && (bus_addr == ADDR_MASK);
    assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

    assign unused_wbits = ^bus_wdata[CFG_PW_LSB-1:CFG_HOST_BIT+1];

    assign active = cfg_host && ((cfg_mode == MODE_ILOCK) || (cfg_mode == MODE_PULSE));
    assign pulsed = (cfg_mode == MODE_PULSE);
    assign pw_eff = (cfg_pw == '0) ? PW_ONE : cfg_pw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_dir  <= 1'b0;
            cfg_host <= 1'b0;
            cfg_mode <= 2'b00;
            cfg_pw   <= '0;
        end else if (wr_cfg) begin
            cfg_dir  <= bus_wdata[CFG_DIR_BIT];
            cfg_host <= bus_wdata[CFG_HOST_BIT];
            cfg_mode <= bus_wdata[CFG_MODE_LSB +: 2];
            cfg_pw   <= bus_wdata[CFG_PW_LSB +: PW_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata[EV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
            tx_q <= '0;
        end else begin
            if (rx_take) rx_q <= pd_in;
            if (tx_go)   tx_q <= bus_wdata[DW-1:0];
        end
    end

    pport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stb_in_n),
        .lvl      (stb_lvl),
        .fell     (stb_fall)
    );

    pport_hs_fsm #(.PW_W(PW_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tx_dir    (cfg_dir),
        .pulsed    (pulsed),
        .pw_eff    (pw_eff),
        .stb_fall  (stb_fall),
        .stb_high  (stb_lvl),
        .data_rd   (rd_data),
        .data_wr   (wr_data),
        .stb_out_n (stb_out_n),
        .rx_take   (rx_take),
        .tx_go     (tx_go),
        .tx_done   (tx_done),
        .ovr_hit   (ovr_hit)
    );

    logic [EV_W-1:0] ev_set;
    always_comb begin
        ev_set         = '0;
        ev_set[EV_RX]  = rx_take;
        ev_set[EV_TX]  = tx_done;
        ev_set[EV_OVR] = ovr_hit;
    end

    pport_evt #(.EW(EV_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (ev_set),
        .clr_we   (wr_evt),
        .clr_bits (bus_wdata[EV_W-1:0]),
        .mask     (mask_q),
        .ev       (ev),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CFG: begin
                bus_rdata[CFG_DIR_BIT]             = cfg_dir;
                bus_rdata[CFG_MODE_LSB +: 2]       = cfg_mode;
                bus_rdata[CFG_HOST_BIT]            = cfg_host;
                bus_rdata[CFG_PW_LSB +: PW_W]      = cfg_pw;
            end
            ADDR_DATA: bus_rdata[DW-1:0]   = rx_q;
            ADDR_EVT:  bus_rdata[EV_W-1:0] = ev;
            ADDR_MASK: bus_rdata[EV_W-1:0] = mask_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pd_out = tx_q;
    assign pd_oe  = cfg_dir;
endmodule

// File: rtl/pport_hs_checker.sv
module pport_hs_checker #(
    parameter int DW   = 8,
    parameter int PW_W = 8,
    parameter int EW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            active,
    input logic            pulsed,
    input logic [PW_W-1:0] pw_eff,
    input logic            stb_out_n,
    input logic            irq,
    input logic [EW-1:0]   ev,
    input logic            rx_take,
    input logic            tx_done,
    input logic            ovr_hit,
    input logic            tx_go,
    input logic [DW-1:0]   wdata_lo,
    input logic [DW-1:0]   pd_out
);
    logic [PW_W:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_cnt <= '0;
        else if (!stb_out_n) low_cnt <= low_cnt + 1'b1;
        else                 low_cnt <= '0;
    end

    assert_inactive_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> stb_out_n);

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_out_n && pulsed) |-> (low_cnt < {1'b0, pw_eff}));

    assert_tx_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> (!stb_out_n && pd_out == $past(wdata_lo)));

    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_hit |=> (ev[2] && $stable(pd_out)));

    assert_rx_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |=> ev[0]);

    assert_tx_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> ev[1]);

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev != '0));
endmodule

bind pport_hs_ctrl pport_hs_checker #(.DW(DW), .PW_W(PW_W), .EW(pport_pkg::EV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .pulsed    (pulsed),
    .pw_eff    (pw_eff),
    .stb_out_n (stb_out_n),
    .irq       (irq),
    .ev        (ev),
    .rx_take   (rx_take),
    .tx_done   (tx_done),
    .ovr_hit   (ovr_hit),
    .tx_go     (tx_go),
    .wdata_lo  (bus_wdata[DW-1:0]),
    .pd_out    (pd_out)
);

// File: tb/tb_pport_hs_ctrl.sv
module tb_pport_hs_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pd_in = '0;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic        stb_in_n = 1'b1;
    logic        stb_out_n;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pport_hs_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pd_in     (pd_in),
        .pd_out    (pd_out),
        .pd_oe     (pd_oe),
        .stb_in_n  (stb_in_n),
        .stb_out_n (stb_out_n),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end on a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 stb_out_n", stb_out_n, 1);
        check("R1 pd_oe", pd_oe, 0);
        check("R1 irq", irq, 0);
        bus_read(2'd0, d); check("R1 cfg", d, 0);
        bus_read(2'd2, d); check("R1 events", d, 0);
        bus_read(2'd3, d); check("R1 mask", d, 0);
    endtask

    task automatic t_invalid();
        logic [15:0] d;
        bus_write(2'd0, 16'h000D);           // software control, mode 10, transmit
        bus_write(2'd1, 16'h0055);
        check("R2 bad mode strobe", stb_out_n, 1);
        check("R2 bad mode data", pd_out, 8'h00);
        stb_in_n = 1'b0; idle(4);
        bus_read(2'd2, d); check("R2 bad mode events", d, 0);
        stb_in_n = 1'b1; idle(3);
        bus_write(2'd0, 16'h0001);           // software control off
        check("R3 oe in transmit", pd_oe, 1);
        bus_write(2'd1, 16'h0066);
        check("R2 host off strobe", stb_out_n, 1);
        check("R2 host off data", pd_out, 8'h00);
    endtask

    task automatic t_rx_interlocked();
        logic [15:0] d;
        bus_write(2'd0, 16'h0008);
        bus_write(2'd2, 16'h0007);
        check("R3 oe in receive", pd_oe, 0);
        pd_in = 8'hA5; stb_in_n = 1'b0; idle(2);
        bus_read(2'd2, d); check("R4 event not before third edge", d, 0);
        bus_read(2'd2, d); check("R4 receive event", d, 1);
        bus_read(2'd1, d); check("R4 latched data", d, 16'h00A5);
        check("R5 ack on read", stb_out_n, 0);
        idle(4); check("R5 ack held", stb_out_n, 0);
        stb_in_n = 1'b1; idle(2);
        check("R5 ack before third edge", stb_out_n, 0);
        idle(1); check("R5 ack released", stb_out_n, 1);
    endtask

    task automatic t_priority();
        logic [15:0] d;
        pd_in = 8'h3E; stb_in_n = 1'b0; idle(2);
        bus_write(2'd2, 16'h0001);           // clear on the same edge as new event
        bus_read(2'd2, d); check("R11 set beats clear", d[0], 1);
        bus_read(2'd1, d); check("R4 second char", d, 16'h003E);
        stb_in_n = 1'b1; idle(3);
        bus_write(2'd2, 16'h0001);
        bus_read(2'd2, d); check("R11 clear", d, 0);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        pd_in = 8'h11; stb_in_n = 1'b0; idle(3);
        check("R12 masked off", irq, 0);
        bus_write(2'd3, 16'h0002);
        check("R12 other bit enabled", irq, 0);
        bus_write(2'd3, 16'h0001);
        check("R12 enabled", irq, 1);
        bus_write(2'd2, 16'h0001);
        check("R12 cleared", irq, 0);
        bus_read(2'd1, d);
        stb_in_n = 1'b1; idle(3);
        bus_write(2'd3, 16'h0000);
    endtask

    task automatic t_rx_pulsed();
        logic [15:0] d;
        bus_write(2'd0, 16'h000A);           // pulsed, length 0 -> 1
        pd_in = 8'h96; stb_in_n = 1'b0; idle(3);
        bus_read(2'd1, d); check("R4 pulsed data", d, 16'h0096);
        check("R6 pulse low", stb_out_n, 0);
        idle(1); check("R6 length 0 is one clock", stb_out_n, 1);
        stb_in_n = 1'b1; idle(3);
        bus_write(2'd0, 16'h020A);           // length 2
        pd_in = 8'h5C; stb_in_n = 1'b0; idle(3);
        bus_read(2'd1, d);
        check("R6 len2 first", stb_out_n, 0);
        idle(1); check("R6 len2 second", stb_out_n, 0);
        idle(1); check("R6 len2 end", stb_out_n, 1);
        stb_in_n = 1'b1; idle(3);
    endtask

    task automatic t_tx_interlocked();
        logic [15:0] d;
        bus_write(2'd0, 16'h0009);
        bus_write(2'd2, 16'h0007);
        check("R3 oe transmit", pd_oe, 1);
        bus_write(2'd1, 16'h003C);
        check("R7 strobe low", stb_out_n, 0);
        check("R7 data out", pd_out, 8'h3C);
        bus_write(2'd1, 16'h0077);
        bus_read(2'd2, d); check("R10 overrun bit", d, 16'h0004);
        check("R10 data kept", pd_out, 8'h3C);
        check("R8 strobe held", stb_out_n, 0);
        stb_in_n = 1'b0; idle(2);
        check("R8 before third edge", stb_out_n, 0);
        idle(1);
        check("R8 strobe released", stb_out_n, 1);
        bus_read(2'd2, d); check("R8 transmit event", d, 16'h0006);
        stb_in_n = 1'b1; idle(3);
    endtask

    task automatic t_tx_pulsed();
        logic [15:0] d;
        bus_write(2'd0, 16'h030B);           // pulsed transmit, length 3
        bus_write(2'd2, 16'h0007);
        bus_write(2'd1, 16'h005A);
        check("R9 pulse 1", stb_out_n, 0);
        idle(1); check("R9 pulse 2", stb_out_n, 0);
        idle(1); check("R6 pulse 3", stb_out_n, 0);
        idle(1); check("R6 pulse end", stb_out_n, 1);
        bus_read(2'd2, d); check("R9 no event before ack", d, 0);
        stb_in_n = 1'b0; idle(2);
        bus_read(2'd2, d); check("R9 event not early", d, 0);
        bus_read(2'd2, d); check("R9 transmit event", d, 16'h0002);
        stb_in_n = 1'b1; idle(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_invalid();
        t_rx_interlocked();
        t_priority();
        t_irq();
        t_rx_pulsed();
        t_tx_interlocked();
        t_tx_pulsed();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule